// File: doc/BRIEF.md
# Dead-Band PWM Generator

This block produces two pulse-width-modulated outputs from a 16-bit counter. The counter runs in one of two modes. In count-down mode it steps from the period value to zero and reloads. In up/down mode it climbs from zero to the period value and then falls back to zero. Two compare values sit alongside the counter. Every time the counter hits zero, the period value, or a compare value, an event pulse is raised. A per-output action table then decides, for each event, whether the output keeps its level, toggles, goes low or goes high.

The period and compare values can take effect at once, or they can be held in shadow registers until the counter next reaches zero, so that a period is never cut short. A dead-band stage follows the action logic and has two settings:

- **Dead-band on:** it turns the first action output into a complementary pair for a half-bridge. The primary's rising edge is delayed by one programmed count. The secondary, which is the inverse of the primary's source, has its rising edge delayed by a second count.
- **Bypass:** both action outputs pass through unchanged.

Each final output has its own enable. All configuration goes through a simple write port.

Top module: `pwm_deadband_gen`

## Requirements
- R1: While reset is high and in the cycle after it, both outputs are low. After reset the counter is zero and every configuration register is zero.
- R2: Count-down mode is selected with control bit 0 (run) set and control bit 1 clear. The counter visits L, L-1, ..., 0 and then reloads L, so each period is L+1 cycles.
- R3: Up/down mode is selected with control bit 1 set. The counter visits 0, 1, ..., L, L-1, ..., 1 and then 0 again, so each period is 2L cycles.
- R4: Each output has a 12-bit action word with six 2-bit fields, one per event:
  - [1:0] zero
  - [3:2] period match
  - [5:4] compare A counting up
  - [7:6] compare A counting down
  - [9:8] compare B counting up
  - [11:10] compare B counting down

  The field codes are 0 keep, 1 toggle, 2 low and 3 high. The output register changes one cycle after the event.
- R5: When several events with non-keep actions coincide, the highest-priority one decides. Priority from highest to lowest is compare B, compare A, period match, zero.
- R6: A compare match is "counting up" when the counter's next step is upward. At zero that step is always up; at the period value it is always down. In count-down mode every compare match counts as down.
- R7: Write addresses are:
  - 0: control
  - 1: period
  - 2: compare A
  - 3: compare B
  - 4: action A
  - 5: action B
  - 6: rising delay
  - 7: falling delay

  Control bit 2 defers period writes and bit 3 defers compare writes. A deferred value takes effect only in the cycle after the counter is zero. A non-deferred value takes effect one cycle after the write.
- R8: With control bit 4 clear, the dead-band stage is bypassed. Each output then follows its action output three cycles after the counter event.
- R9: With control bit 4 set, output A is action output A with its rising edge delayed by the rising-delay count. Output B is the inverse of action output A with its rising edge delayed by the falling-delay count. Both falling edges are immediate, and the two outputs are never high together.
- R10: Control bits 5 and 6 enable outputs A and B. A disabled output is low from the next cycle onward.
- R11: While run is clear, the counter is held at zero, no events occur, and both outputs hold their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Final output A (primary) |
| pwm_b | output | 1 | Final output B (secondary) |

## Verification
Results fall due on a fixed schedule:

- A register write is visible at the edge that captures it.
- A non-deferred period or compare value is used one cycle later.
- An event seen at counter value k reaches the output pins three edges later: action register, then dead-band register, then output register.

The bench keeps a cycle-level model stepped at the same rising edges as the design. It compares both pins with the model at every falling edge, so each result is checked in exactly the cycle it becomes due. Directed period and pulse-width measurements are also taken between output edges seen at falling edges; these need no latency offset.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

  localparam int REG_AW = 3;
  localparam int CTRL_W = 7;

  localparam logic [REG_AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] ADR_PER  = 3'd1;
  localparam logic [REG_AW-1:0] ADR_CMPA = 3'd2;
  localparam logic [REG_AW-1:0] ADR_CMPB = 3'd3;
  localparam logic [REG_AW-1:0] ADR_ACTA = 3'd4;
  localparam logic [REG_AW-1:0] ADR_ACTB = 3'd5;
  localparam logic [REG_AW-1:0] ADR_RISE = 3'd6;
  localparam logic [REG_AW-1:0] ADR_FALL = 3'd7;

  localparam int CB_RUN  = 0;
  localparam int CB_UPDN = 1;
  localparam int CB_DEFP = 2;
  localparam int CB_DEFC = 3;
  localparam int CB_DBEN = 4;
  localparam int CB_ENA  = 5;
  localparam int CB_ENB  = 6;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_FLIP = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_SET  = 2'd3
  } act_e;

  typedef struct packed {
    act_e cmpb_dn;
    act_e cmpb_up;
    act_e cmpa_dn;
    act_e cmpa_up;
    act_e at_per;
    act_e at_zero;
  } act_cfg_t;

  localparam int ACT_W = $bits(act_cfg_t);

  typedef struct packed {
    logic zero;
    logic per;
    logic a_up;
    logic a_dn;
    logic b_up;
    logic b_dn;
  } evt_t;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          updown,
  input  logic [CW-1:0] per_now,
  input  logic [CW-1:0] per_next,
  output logic [CW-1:0] cnt,
  output logic          go_up
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic          up_q;
  logic [CW-1:0] lim;
  logic [CW-1:0] nxt;

  always_comb begin
    go_up = updown && ((cnt == '0) || (up_q && (cnt < per_now)));
    lim   = (cnt == '0) ? per_next : per_now;
    if (!updown)
      nxt = (cnt == '0) ? per_next : cnt - ONE;
    else if (lim == '0)
      nxt = '0;
    else if (go_up)
      nxt = cnt + ONE;
    else
      nxt = cnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else begin
      cnt  <= nxt;
      up_q <= go_up;
    end
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_db_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  evt_t     evt,
  input  act_cfg_t cfg,
  output logic     q
);
  act_e code;

  // ascending priority: later matches override earlier ones
  always_comb begin
    code = ACT_KEEP;
    if (evt.zero && cfg.at_zero != ACT_KEEP) code = cfg.at_zero;
    if (evt.per  && cfg.at_per  != ACT_KEEP) code = cfg.at_per;
    if (evt.a_up && cfg.cmpa_up != ACT_KEEP) code = cfg.cmpa_up;
    if (evt.a_dn && cfg.cmpa_dn != ACT_KEEP) code = cfg.cmpa_dn;
    if (evt.b_up && cfg.cmpb_up != ACT_KEEP) code = cfg.cmpb_up;
    if (evt.b_dn && cfg.cmpb_dn != ACT_KEEP) code = cfg.cmpb_dn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (code)
        ACT_FLIP: q <= ~q;
        ACT_CLR:  q <= 1'b0;
        ACT_SET:  q <= 1'b1;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pwm_edge_delay.sv
module pwm_edge_delay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [DW-1:0] dly,
  output logic          dout
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !din) begin
      cnt  <= '0;
      dout <= 1'b0;
    end else if (cnt >= dly) begin
      dout <= 1'b1;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          db_en,
  input  logic          in_a,
  input  logic          in_b,
  input  logic [DW-1:0] rise,
  input  logic [DW-1:0] fall,
  output logic          out_a,
  output logic          out_b
);
  logic [1:0] src;
  logic [1:0] dly_q;
  logic       byp_a;
  logic       byp_b;

  assign src = {~in_a, in_a};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    pwm_edge_delay #(.DW(DW)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .din  (src[g]),
      .dly  ((g == 0) ? rise : fall),
      .dout (dly_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_a <= 1'b0;
      byp_b <= 1'b0;
    end else begin
      byp_a <= in_a;
      byp_b <= in_b;
    end
  end

  assign out_a = db_en ? dly_q[0] : byp_a;
  assign out_b = db_en ? dly_q[1] : byp_b;
endmodule

// File: rtl/pwm_deadband_gen.sv
module pwm_deadband_gen
  import pwm_db_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     per_sh, per_act;
  logic [CW-1:0]     cmpa_sh, cmpa_act;
  logic [CW-1:0]     cmpb_sh, cmpb_act;
  act_cfg_t          act_cfg [2];
  logic [DW-1:0]     rise_q, fall_q;

  logic run_en, updn_en, defp_en, defc_en, dben, ena, enb;
  assign run_en  = ctrl_q[CB_RUN];
  assign updn_en = ctrl_q[CB_UPDN];
  assign defp_en = ctrl_q[CB_DEFP];
  assign defc_en = ctrl_q[CB_DEFC];
  assign dben    = ctrl_q[CB_DBEN];
  assign ena     = ctrl_q[CB_ENA];
  assign enb     = ctrl_q[CB_ENB];

  logic [CW-1:0] cnt;
  logic          go_up;
  logic          take_per, take_cmp;
  logic [CW-1:0] per_next;

  assign take_per = !run_en || !defp_en || (cnt == '0);
  assign take_cmp = !run_en || !defc_en || (cnt == '0);
  assign per_next = take_per ? per_sh : per_act;

  // register write port
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      per_sh     <= '0;
      cmpa_sh    <= '0;
      cmpb_sh    <= '0;
      act_cfg[0] <= '0;
      act_cfg[1] <= '0;
      rise_q     <= '0;
      fall_q     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: ctrl_q     <= wr_data[CTRL_W-1:0];
        ADR_PER:  per_sh     <= wr_data;
        ADR_CMPA: cmpa_sh    <= wr_data;
        ADR_CMPB: cmpb_sh    <= wr_data;
        ADR_ACTA: act_cfg[0] <= act_cfg_t'(wr_data[ACT_W-1:0]);
        ADR_ACTB: act_cfg[1] <= act_cfg_t'(wr_data[ACT_W-1:0]);
        ADR_RISE: rise_q     <= wr_data[DW-1:0];
        default:  fall_q     <= wr_data[DW-1:0];
      endcase
    end
  end

  // shadow to active transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      per_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else begin
      if (take_per) per_act <= per_sh;
      if (take_cmp) begin
        cmpa_act <= cmpa_sh;
        cmpb_act <= cmpb_sh;
      end
    end
  end

  pwm_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (run_en),
    .updown   (updn_en),
    .per_now  (per_act),
    .per_next (per_next),
    .cnt      (cnt),
    .go_up    (go_up)
  );

  evt_t evt;
  always_comb begin
    evt.zero = run_en && (cnt == '0);
    evt.per  = run_en && (cnt == per_act);
    evt.a_up = run_en && (cnt == cmpa_act) &&  go_up;
    evt.a_dn = run_en && (cnt == cmpa_act) && !go_up;
    evt.b_up = run_en && (cnt == cmpb_act) &&  go_up;
    evt.b_dn = run_en && (cnt == cmpb_act) && !go_up;
  end

  logic [1:0] raw;
  for (genvar g = 0; g < 2; g++) begin : g_act
    pwm_action u_act (
      .clk (clk),
      .rst (rst),
      .evt (evt),
      .cfg (act_cfg[g]),
      .q   (raw[g])
    );
  end

  logic db_a, db_b;
  pwm_deadband #(.DW(DW)) u_db (
    .clk   (clk),
    .rst   (rst),
    .db_en (dben),
    .in_a  (raw[0]),
    .in_b  (raw[1]),
    .rise  (rise_q),
    .fall  (fall_q),
    .out_a (db_a),
    .out_b (db_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
    end else begin
      pwm_a <= ena & db_a;
      pwm_b <= enb & db_b;
    end
  end
endmodule

// File: rtl/pwm_deadband_gen_chk.sv
module pwm_deadband_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run_en,
  input logic          updn_en,
  input logic          defp_en,
  input logic          ena,
  input logic          enb,
  input logic          dben,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_act,
  input logic          db_a,
  input logic          db_b,
  input logic          pwm_a,
  input logic          pwm_b
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!pwm_a && !pwm_b));

  p_down_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run_en && !updn_en && cnt != '0) |=> (!run_en || updn_en || cnt == $past(cnt) - ONE));

  p_updown_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run_en && updn_en && cnt != '0) |=>
      (!run_en || !updn_en || cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

  p_defer_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (run_en && defp_en && cnt != '0) |=> $stable(per_act));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    dben |-> !(db_a && db_b));

  p_gate_a_r10: assert property (@(posedge clk) disable iff (rst)
    !ena |=> !pwm_a);

  p_gate_b_r10: assert property (@(posedge clk) disable iff (rst)
    !enb |=> !pwm_b);

  p_halt_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (cnt == '0));
endmodule

bind pwm_deadband_gen pwm_deadband_gen_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run_en  (run_en),
  .updn_en (updn_en),
  .defp_en (defp_en),
  .ena     (ena),
  .enb     (enb),
  .dben    (dben),
  .cnt     (cnt),
  .per_act (per_act),
  .db_a    (db_a),
  .db_b    (db_b),
  .pwm_a   (pwm_a),
  .pwm_b   (pwm_b)
);

// File: tb/pwm_deadband_gen_tb.sv
`timescale 1ns/1ps
module pwm_deadband_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;

  always #5 clk = ~clk;

  pwm_deadband_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur    = "R1";
  bit    cmp_on = 1'b0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- cycle model built from the requirements ----------------
  logic [6:0]  m_ctrl;
  logic [15:0] m_per_sh, m_per, m_ca_sh, m_ca, m_cb_sh, m_cb, m_cnt;
  logic [11:0] m_act_a, m_act_b;
  logic [7:0]  m_rise, m_fall, m_dc_a, m_dc_b;
  logic        m_up, m_raw_a, m_raw_b, m_dd_a, m_dd_b, m_byp_a, m_byp_b;
  logic        m_out_a, m_out_b;
  logic        t_run, t_tp, t_tc, t_go;
  logic [15:0] t_pn, t_lim, t_nxt;
  logic        ez, ep, eau, ead, ebu, ebd;

  function automatic logic next_out(input logic cur_v, input logic [11:0] cfg,
      input logic z, input logic p, input logic au, input logic ad,
      input logic bu, input logic bd);
    logic [1:0] code;
    code = 2'd0;
    if (z  && cfg[1:0]   != 0) code = cfg[1:0];
    if (p  && cfg[3:2]   != 0) code = cfg[3:2];
    if (au && cfg[5:4]   != 0) code = cfg[5:4];
    if (ad && cfg[7:6]   != 0) code = cfg[7:6];
    if (bu && cfg[9:8]   != 0) code = cfg[9:8];
    if (bd && cfg[11:10] != 0) code = cfg[11:10];
    case (code)
      2'd1:    return ~cur_v;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return cur_v;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl <= '0; m_per_sh <= '0; m_per <= '0; m_ca_sh <= '0; m_ca <= '0;
      m_cb_sh <= '0; m_cb <= '0; m_cnt <= '0; m_act_a <= '0; m_act_b <= '0;
      m_rise <= '0; m_fall <= '0; m_dc_a <= '0; m_dc_b <= '0; m_up <= 1'b1;
      m_raw_a <= 0; m_raw_b <= 0; m_dd_a <= 0; m_dd_b <= 0;
      m_byp_a <= 0; m_byp_b <= 0; m_out_a <= 0; m_out_b <= 0;
    end else begin
      t_run = m_ctrl[0];
      t_tp  = !t_run || !m_ctrl[2] || (m_cnt == 0);
      t_tc  = !t_run || !m_ctrl[3] || (m_cnt == 0);
      t_pn  = t_tp ? m_per_sh : m_per;
      t_go  = m_ctrl[1] && ((m_cnt == 0) || (m_up && m_cnt < m_per));
      t_lim = (m_cnt == 0) ? t_pn : m_per;
      if (!t_run)                t_nxt = 0;
      else if (!m_ctrl[1])       t_nxt = (m_cnt == 0) ? t_pn : m_cnt - 16'd1;
      else if (t_lim == 0)       t_nxt = 0;
      else                       t_nxt = t_go ? m_cnt + 16'd1 : m_cnt - 16'd1;
      ez  = t_run && m_cnt == 0;
      ep  = t_run && m_cnt == m_per;
      eau = t_run && m_cnt == m_ca &&  t_go;
      ead = t_run && m_cnt == m_ca && !t_go;
      ebu = t_run && m_cnt == m_cb &&  t_go;
      ebd = t_run && m_cnt == m_cb && !t_go;
      m_cnt   <= t_nxt;
      m_up    <= t_run ? t_go : 1'b1;
      m_raw_a <= next_out(m_raw_a, m_act_a, ez, ep, eau, ead, ebu, ebd);
      m_raw_b <= next_out(m_raw_b, m_act_b, ez, ep, eau, ead, ebu, ebd);
      if (!m_raw_a) begin m_dc_a <= 0; m_dd_a <= 0; end
      else if (m_dc_a >= m_rise) m_dd_a <= 1;
      else m_dc_a <= m_dc_a + 8'd1;
      if (m_raw_a) begin m_dc_b <= 0; m_dd_b <= 0; end
      else if (m_dc_b >= m_fall) m_dd_b <= 1;
      else m_dc_b <= m_dc_b + 8'd1;
      m_byp_a <= m_raw_a;
      m_byp_b <= m_raw_b;
      m_out_a <= m_ctrl[5] & (m_ctrl[4] ? m_dd_a : m_byp_a);
      m_out_b <= m_ctrl[6] & (m_ctrl[4] ? m_dd_b : m_byp_b);
      if (t_tp) m_per <= m_per_sh;
      if (t_tc) begin m_ca <= m_ca_sh; m_cb <= m_cb_sh; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl   <= wr_data[6:0];
          3'd1: m_per_sh <= wr_data;
          3'd2: m_ca_sh  <= wr_data;
          3'd3: m_cb_sh  <= wr_data;
          3'd4: m_act_a  <= wr_data[11:0];
          3'd5: m_act_b  <= wr_data[11:0];
          3'd6: m_rise   <= wr_data[7:0];
          default: m_fall <= wr_data[7:0];
        endcase
      end
    end
  end

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur, pwm_a, m_out_a, "pwm_a vs model");
      chk(cur, pwm_b, m_out_b, "pwm_b vs model");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic pin(input bit sel);
    return sel ? pwm_b : pwm_a;
  endfunction

  task automatic wait_rise(input bit sel);
    logic pv;
    pv = pin(sel);
    forever begin
      @(negedge clk);
      if (pin(sel) && !pv) break;
      pv = pin(sel);
    end
  endtask

  task automatic rise_gap(input bit sel, output int n);
    logic pv;
    wait_rise(sel);
    n = 0; pv = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (pin(sel) && !pv) break;
      pv = pin(sel);
    end
  endtask

  task automatic high_width(input bit sel, output int n);
    wait_rise(sel);
    n = 0;
    while (pin(sel)) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before the end of the run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic ha, hb;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", pwm_a, 0, "pwm_a after reset");
    chk("R1", pwm_b, 0, "pwm_b after reset");
    cmp_on = 1'b1;

    // R2: count-down, period 10
    cur = "R2";
    wr(3'd1, 16'd9); wr(3'd2, 16'd6); wr(3'd3, 16'd2);
    wr(3'd4, 16'h083); wr(3'd5, 16'h80C); wr(3'd0, 16'h061);
    repeat (30) @(negedge clk);
    rise_gap(0, n); chk("R2", n, 10, "down-mode period A");
    rise_gap(1, n); chk("R2", n, 10, "down-mode period B");

    // R5: zero sets, compare A at zero clears -> compare wins
    cur = "R5";
    wr(3'd0, 16'h060); wr(3'd2, 16'd0); wr(3'd1, 16'd5); wr(3'd0, 16'h061);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R5", pwm_a, 0, "priority compare over zero");
      @(negedge clk);
    end

    // R3 / R6 / R4: up/down mode
    cur = "R3";
    wr(3'd0, 16'h060); wr(3'd1, 16'd8); wr(3'd2, 16'd3);
    wr(3'd4, 16'h0B0); wr(3'd5, 16'h001); wr(3'd0, 16'h063);
    repeat (20) @(negedge clk);
    rise_gap(0, n);   chk("R3", n, 16, "up/down period");
    high_width(0, n); chk("R6", n, 10, "up-set/down-clear width");
    rise_gap(1, n);   chk("R4", n, 32, "toggle-on-zero period");

    // R7: deferred then immediate period writes
    cur = "R7";
    wr(3'd0, 16'h060); wr(3'd1, 16'd9); wr(3'd2, 16'd2);
    wr(3'd4, 16'h083); wr(3'd0, 16'h065);
    repeat (23) @(negedge clk);
    wr(3'd1, 16'd4);
    repeat (15) @(negedge clk);
    rise_gap(0, n); chk("R7", n, 5, "deferred period");
    wr(3'd0, 16'h061); wr(3'd1, 16'd7);
    repeat (12) @(negedge clk);
    rise_gap(0, n); chk("R7", n, 8, "immediate period");

    // R8 / R9: bypass vs dead-band
    cur = "R8";
    wr(3'd0, 16'h060); wr(3'd1, 16'd19); wr(3'd2, 16'd10);
    wr(3'd6, 16'd3); wr(3'd7, 16'd5); wr(3'd0, 16'h061);
    repeat (25) @(negedge clk);
    high_width(0, n); chk("R8", n, 10, "bypass high width");
    cur = "R9";
    wr(3'd0, 16'h071);
    repeat (25) @(negedge clk);
    high_width(0, n); chk("R9", n, 7, "primary with rising delay");
    high_width(1, n); chk("R9", n, 5, "secondary with falling delay");

    // R10: output A disabled
    cur = "R10";
    wr(3'd0, 16'h051);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      repeat (7) @(negedge clk);
      chk("R10", pwm_a, 0, "disabled output A");
    end

    // R11: stop holds levels
    cur = "R11";
    wr(3'd0, 16'h071);
    repeat (13) @(negedge clk);
    wr(3'd0, 16'h070);
    repeat (4) @(negedge clk);
    ha = pwm_a; hb = pwm_b;
    for (int i = 0; i < 5; i++) begin
      repeat (4) @(negedge clk);
      chk("R11", pwm_a, ha, "pwm_a held while stopped");
      chk("R11", pwm_b, hb, "pwm_b held while stopped");
    end

    // R4: random configurations against the model
    cur = "R4";
    for (int r = 0; r < 25; r++) begin
      logic [15:0] per;
      per = 16'($urandom_range(1, 40));
      wr(3'd0, 16'h000);
      wr(3'd1, per);
      wr(3'd2, 16'($urandom_range(0, 42)));
      wr(3'd3, 16'($urandom_range(0, 42)));
      wr(3'd4, 16'($urandom_range(0, 4095)));
      wr(3'd5, 16'($urandom_range(0, 4095)));
      wr(3'd6, 16'($urandom_range(0, 7)));
      wr(3'd7, 16'($urandom_range(0, 7)));
      wr(3'd0, 16'($urandom_range(0, 127)) | 16'h1);
      repeat (60) @(negedge clk);
      if ($urandom_range(0, 1) == 1) wr(3'd1, 16'($urandom_range(1, 40)));
      if ($urandom_range(0, 1) == 1) wr(3'd2, 16'($urandom_range(0, 42)));
      repeat (60) @(negedge clk);
    end

    cmp_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule